// File: doc/BRIEF.md
# Power-Up Reset and Serial Configuration Sequencer

This controller sits on the host side of a data converter. It takes the converter from power-up to a configured state. It waits for a supply-good indication, holds off for a power-on delay, and drives an active-high reset pulse to the device. After a further settling gap it opens one serial frame on a three-wire bus: an active-low enable, a clock that idles low, and a data line. Inside that frame it streams a fixed number of 16-bit configuration words, back to back.

Each word is read from the host through a small lookup port. The sequencer presents a word index, and the host returns the word for that index on the same cycle. Each word holds a 4-bit register address in its upper nibble and 12 data bits below it, and is shifted out most significant bit first. The device samples data on falling clock edges, so the sequencer changes data only when the serial clock rises.

All delays are given in nanoseconds and converted to clock cycles from the system clock frequency, rounding up so that no minimum is shortened. The serial clock period is a parameterized even divisor of the system clock. If supply-good drops at any point, everything restarts from the beginning.

Top module: `pwrup_cfg_seq`

## Requirements
- R1: While `rst_n` is low, `dev_reset`=0, `sen_n`=1, `sclk`=0, `sdata`=0, `busy`=0, `done`=0 and `cfg_idx`=0.
- R2: When `supply_ok` is seen high in the idle state, `busy` rises on the next cycle and stays high for exactly PWR cycles before `dev_reset` rises, where PWR = ceil(PWR_NS*CLK_HZ/1e9), with a minimum of 1.
- R3: `dev_reset` stays high for exactly ceil(RST_NS*CLK_HZ/1e9) cycles, and `sen_n` is never low while `dev_reset` is high.
- R4: Between the fall of `dev_reset` and the fall of `sen_n` there are exactly ceil(SET_NS*CLK_HZ/1e9) cycles, rounded up (33 ns at 200 MHz gives 7 cycles).
- R5: After `sen_n` falls, `sclk` stays low for SCLK_DIV/2 cycles before its first rise, and `sdata` already carries bit 15 of word 0.
- R6: `sclk` is high for SCLK_DIV/2 cycles and low for SCLK_DIV/2 cycles per bit, and toggles only while `sen_n` is low. Within a frame, `sdata` changes only in a cycle where `sclk` rises.
- R7: Word k is taken from `cfg_word` while `cfg_idx`=k and sent unchanged, bit 15 first: address in bits 15:12, data in bits 11:0.
- R8: All NUM_WORDS words (16 falling `sclk` edges each) go out in one `sen_n` low period, and `cfg_idx` never reaches NUM_WORDS.
- R9: After the last falling `sclk` edge, `sen_n` stays low for SCLK_DIV/2 more cycles and then rises.
- R10: Once `sen_n` rises at the end of the frame, `done`=1 and `busy`=0. This holds with no further bus activity while `supply_ok` stays high.
- R11: `supply_ok` low in any state makes the next cycle idle (`dev_reset`=0, `sen_n`=1, `sclk`=0, `busy`=0, `done`=0). A later rise of `supply_ok` runs the complete sequence again.
- R12: If `supply_ok` drops in the same cycle that the last bit period ends, the restart wins and `done` does not rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Converter supplies are up |
| cfg_word | input | 16 | Configuration word for the index on `cfg_idx` |
| cfg_idx | output | IW | Index of the word currently being sent |
| dev_reset | output | 1 | Active-high reset pulse to the device |
| sen_n | output | 1 | Serial enable, active low |
| sclk | output | 1 | Serial clock, idles low |
| sdata | output | 1 | Serial data, MSB first |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | All words written |

## Verification
Two events can land on the same clock edge: the end of the final bit period, which would move the sequencer to its finished state, and a drop of `supply_ok`, which forces a restart. The bench follows the frame through the port outputs. It waits for the sample where the last word is captured and the trailing low half of the clock has run its full length. In that same cycle it pulls `supply_ok` low. The expected result is that `done` never rises, `sen_n` returns high, and `busy` is low on the next sample. A clean rerun afterwards must still deliver every word.

// File: rtl/pwrup_cfg_seq.sv
`timescale 1ns/1ps
module pwrup_cfg_seq #(
  parameter longint CLK_HZ    = 100_000_000,
  parameter longint PWR_NS    = 10_000_000,
  parameter longint RST_NS    = 2_000,
  parameter longint SET_NS    = 2_000,
  parameter int     SCLK_DIV  = 8,
  parameter int     NUM_WORDS = 4,
  localparam int    IW        = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic [15:0]   cfg_word,
  output logic [IW-1:0] cfg_idx,
  output logic          dev_reset,
  output logic          sen_n,
  output logic          sclk,
  output logic          sdata,
  output logic          busy,
  output logic          done
);

  function automatic longint to_cyc(longint ns);
    longint c;
    c = (ns * CLK_HZ + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam longint PWR_CYC = to_cyc(PWR_NS);
  localparam longint RST_CYC = to_cyc(RST_NS);
  localparam longint SET_CYC = to_cyc(SET_NS);
  localparam longint MAX_CYC = (PWR_CYC > RST_CYC) ?
                               ((PWR_CYC > SET_CYC) ? PWR_CYC : SET_CYC) :
                               ((RST_CYC > SET_CYC) ? RST_CYC : SET_CYC);
  localparam int CW   = $clog2(MAX_CYC + 1);
  localparam int HALF = SCLK_DIV / 2;
  localparam int PW   = $clog2(SCLK_DIV);

  typedef enum logic [2:0] {S_IDLE, S_PWR, S_RST, S_SET, S_LEAD, S_SHIFT, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] ph;
  logic [3:0]    bitc;
  logic [IW-1:0] idx;

  wire in_frame = (st == S_LEAD) || (st == S_SHIFT);
  wire ph_end   = (ph == PW'(SCLK_DIV - 1));

  assign cfg_idx   = idx;
  assign dev_reset = (st == S_RST);
  assign sen_n     = !in_frame;
  assign sclk      = (st == S_SHIFT) && (ph < PW'(HALF));
  assign sdata     = in_frame ? cfg_word[4'd15 - bitc] : 1'b0;
  assign busy      = (st != S_IDLE) && (st != S_DONE);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ph <= '0; bitc <= '0; idx <= '0;
    end else if (!supply_ok) begin
      st <= S_IDLE; cnt <= '0; ph <= '0; bitc <= '0; idx <= '0;
    end else begin
      case (st)
        S_IDLE: begin cnt <= '0; st <= S_PWR; end
        S_PWR:
          if (cnt == CW'(PWR_CYC - 1)) begin cnt <= '0; st <= S_RST; end
          else cnt <= cnt + CW'(1);
        S_RST:
          if (cnt == CW'(RST_CYC - 1)) begin cnt <= '0; st <= S_SET; end
          else cnt <= cnt + CW'(1);
        S_SET:
          if (cnt == CW'(SET_CYC - 1)) begin cnt <= '0; ph <= '0; st <= S_LEAD; end
          else cnt <= cnt + CW'(1);
        S_LEAD:
          if (ph == PW'(HALF - 1)) begin ph <= '0; st <= S_SHIFT; end
          else ph <= ph + PW'(1);
        S_SHIFT:
          if (ph_end) begin
            ph   <= '0;
            bitc <= bitc + 4'd1;
            if (bitc == 4'd15) begin
              if (idx == IW'(NUM_WORDS - 1)) st <= S_DONE;
              else idx <= idx + IW'(1);
            end
          end else ph <= ph + PW'(1);
        default: st <= st;
      endcase
    end
  end

  AST_RST_BLOCKS_SEN: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> sen_n); // R3
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !sen_n); // R6
  AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sen_n && !$past(sen_n) && (sdata != $past(sdata))) |-> (sclk && !$past(sclk))); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cfg_idx) < NUM_WORDS); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sen_n && !sclk && !dev_reset)); // R10
  AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!busy && !done && sen_n && !dev_reset)); // R11
  AST_DONE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(supply_ok)); // R12

endmodule

// File: tb/sim_pwrup_cfg_seq.sv
`timescale 1ns/1ps
module sim_pwrup_cfg_seq;
  localparam int NW   = 3;
  localparam int HALF = 2;
  localparam int EXP_PWR = 40, EXP_RST = 10, EXP_SET = 7;

  logic clk = 0, rst_n = 0, supply_ok = 0;
  logic [15:0] cfg_word;
  logic [1:0]  cfg_idx;
  logic dev_reset, sen_n, sclk, sdata, busy, done;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] tbl(int i);
    case (i)
      0: return 16'h8001;
      1: return 16'h7FFE;
      2: return 16'h3A5C;
      default: return 16'hFFFF;
    endcase
  endfunction
  assign cfg_word = tbl(int'(cfg_idx));

  pwrup_cfg_seq #(.CLK_HZ(200_000_000), .PWR_NS(200), .RST_NS(50), .SET_NS(33),
                  .SCLK_DIV(4), .NUM_WORDS(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cfg_word(cfg_word),
    .cfg_idx(cfg_idx), .dev_reset(dev_reset), .sen_n(sen_n), .sclk(sclk),
    .sdata(sdata), .busy(busy), .done(done));

  int n_chk = 0, n_bad = 0;
  int pwr_n, rst_w, set_n, lead_n, low_run, hi_run, bits, words, viol, bad_hi, bad_lo;
  bit seen_rst, seen_clk;
  logic [15:0] sh;
  logic [15:0] got [0:7];
  logic p_sclk = 0, p_sen = 1, p_sd = 0;

  task automatic mon_clr;
    pwr_n = 0; rst_w = 0; set_n = 0; lead_n = 0; low_run = 0; hi_run = 0;
    bits = 0; words = 0; viol = 0; bad_hi = 0; bad_lo = 0;
    seen_rst = 0; seen_clk = 0; sh = '0;
  endtask

  always @(negedge clk) begin
    if (busy && !seen_rst && !dev_reset) pwr_n++;
    if (dev_reset) begin rst_w++; seen_rst = 1; end
    if (seen_rst && !dev_reset && sen_n && busy) set_n++;
    if (!sen_n && !seen_clk && !sclk) lead_n++;
    if (sclk) begin seen_clk = 1; hi_run++; end
    if (!sen_n && !p_sen && sdata != p_sd && !(sclk && !p_sclk)) viol++;
    if (sclk && !p_sclk && bits > 0 && low_run != HALF) bad_lo++;
    if (p_sclk && !sclk && !sen_n) begin
      if (hi_run != HALF) bad_hi++;
      hi_run = 0;
      sh = {sh[14:0], sdata};
      bits++;
      if (bits % 16 == 0 && words < 8) begin got[words] = sh; words++; end
      low_run = 1;
    end else if (!sen_n && !sclk && seen_clk) low_run++;
    p_sclk = sclk; p_sen = sen_n; p_sd = sdata;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step; @(negedge clk); #1; endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    report();
  end

  task automatic t_reset;
    rst_n = 0; supply_ok = 0;
    repeat (3) step();
    check("R1 dev_reset", dev_reset, 0);
    check("R1 sen_n", sen_n, 1);
    check("R1 sclk", sclk, 0);
    check("R1 sdata", sdata, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 cfg_idx", cfg_idx, 0);
    rst_n = 1; step();
  endtask

  task automatic t_full(string tag);
    mon_clr();
    supply_ok = 1;
    for (int i = 0; i < 3000 && !done; i++) step();
    check({tag, " R2 power-on delay"}, pwr_n, EXP_PWR);
    check({tag, " R3 reset width"}, rst_w, EXP_RST);
    check({tag, " R4 settle gap"}, set_n, EXP_SET);
    check({tag, " R5 lead"}, lead_n, HALF);
    check({tag, " R6 data change off rise"}, viol, 0);
    check({tag, " R6 high width"}, bad_hi, 0);
    check({tag, " R6 low width"}, bad_lo, 0);
    check({tag, " R8 word count"}, words, NW);
    for (int k = 0; k < NW; k++) check({tag, " R7 word"}, got[k], tbl(k));
    check({tag, " R7 address nibble"}, got[1][15:12], 4'h7);
    check({tag, " R9 trail"}, low_run, HALF);
    check({tag, " R10 done"}, done, 1);
    check({tag, " R10 busy"}, busy, 0);
  endtask

  task automatic t_stay_done;
    int b0;
    b0 = bits;
    repeat (50) step();
    check("R10 done held", done, 1);
    check("R10 no more edges", bits, b0);
    check("R10 sen_n idle", sen_n, 1);
  endtask

  task automatic t_drop_shift;
    supply_ok = 0; step();
    check("R11 drop from done", done, 0);
    step();
    mon_clr(); supply_ok = 1;
    for (int i = 0; i < 3000 && words < 1; i++) step();
    repeat (9) step();
    check("R11 mid-frame precondition", sen_n, 0);
    supply_ok = 0; step();
    check("R11 sen_n released", sen_n, 1);
    check("R11 sclk low", sclk, 0);
    check("R11 busy cleared", busy, 0);
    step();
  endtask

  task automatic t_drop_reset;
    mon_clr(); supply_ok = 1;
    for (int i = 0; i < 3000 && rst_w < 3; i++) step();
    check("R11 in reset", dev_reset, 1);
    supply_ok = 0; step();
    check("R11 reset released", dev_reset, 0);
    step();
  endtask

  task automatic t_collide;
    bit hit;
    hit = 0;
    mon_clr(); supply_ok = 1;
    for (int i = 0; i < 3000 && !hit; i++) begin
      step();
      if (words == NW && low_run == HALF && !sen_n) hit = 1;
    end
    check("R12 reached last cycle", int'(hit), 1);
    supply_ok = 0; step();
    check("R12 done suppressed", done, 0);
    check("R12 busy", busy, 0);
    check("R12 sen_n", sen_n, 1);
    repeat (5) step();
    check("R12 done stays low", done, 0);
  endtask

  initial begin
    t_reset();
    t_full("first");
    t_stay_done();
    t_drop_shift();
    t_full("restart");
    supply_ok = 0; step();
    t_drop_reset();
    t_full("after reset drop");
    supply_ok = 0; step();
    t_collide();
    t_full("after collision");
    report();
  end
endmodule